// File: doc/BRIEF.md
# Pulse-and-Verify Byte Programming Sequencer

This block writes a run of bytes into an attached erasable one-time-writable memory. That memory can only clear bits from 1 to 0, and it needs repeated program strobes before a cell holds its value. For each target address the sequencer fetches the byte from a byte source and places address and data on the memory bus. It then applies a fixed-width active-low program strobe and reads the location back. Strobes repeat until the read-back equals the wanted byte, up to a fixed pulse limit.

A caller presents a start address and a byte count and pulses `start`. The block raises `busy` and walks the addresses upward one by one. It ends with a one-cycle `done`. When a location cannot be programmed, the block stops at once and raises `error` together with `done`. In that case `failAddr` holds the offending address. While a job runs, a level flag asks the board to switch on the programming supply. The strobe width and the setup and settle intervals are parameters counted in clock cycles.

Top module: `burn_sequencer`

## Requirements
- R1: After reset `busy`, `done` and `error` are low, `memCeN`, `memOeN` and `memPgmN` are high, `highSupply` is low, and `memDataOe` is low.
- R2: `start` is accepted only while the block is idle. A `start` given while `busy` is high has no effect on the running job and does not begin another one.
- R3: Every program strobe holds `memPgmN` low for exactly PULSE_CYC consecutive cycles and then returns it high. Throughout the strobe `memOeN` is high, `memCeN` is low, `highSupply` is high and `memDataOe` is high.
- R4: Before each falling edge of `memPgmN`, `memAddr` and `memDataOut` are driven (`memDataOe` high, `memPgmN` high) for at least SETUP_CYC cycles. Neither changes while the strobe is low.
- R5: After each strobe the block reads back with `memCeN` low, `memOeN` low, `memPgmN` high and `memDataOe` low. This window lasts SETTLE_CYC+1 cycles, and the data is compared in its last cycle.
- R6: Strobing of an address stops at the first read-back equal to the wanted byte. An address that needs n strobes (1 ≤ n ≤ MAX_PULSES) receives exactly n.
- R7: No address receives more than MAX_PULSES (10) strobes. A mismatch after the tenth strobe ends the job with `error` and `done` high, and `failAddr` holds that address.
- R8: A read-back that shows a 0 in a bit position where the wanted byte has a 1 ends the job at once, with no further strobe, as an error at that address.
- R9: Bytes go to addresses startAddr, startAddr+1, … startAddr+length−1 in rising order. The byte for each address is taken from `srcByte` while `srcAddr` equals that address. No location outside the range is strobed.
- R10: `done` is high for exactly one cycle at the end of a job. `error` and `failAddr` keep their values until the next accepted `start`. After the job `highSupply` is low and the memory controls are idle.
- R11: A start with length 0 produces `done` on the next cycle with no strobe and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (one-cycle pulse, sampled while idle) |
| startAddr | input | ADDR_W | First target address |
| length | input | LEN_W | Number of bytes to program |
| srcAddr | output | ADDR_W | Address requested from the byte source |
| srcByte | input | DATA_W | Byte returned by the source for `srcAddr` (same cycle) |
| memAddr | output | ADDR_W | Memory address bus |
| memDataOut | output | DATA_W | Data driven to the memory while programming |
| memDataOe | output | 1 | Drive enable for `memDataOut` |
| memDataIn | input | DATA_W | Data read back from the memory |
| memCeN | output | 1 | Memory chip enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memPgmN | output | 1 | Program strobe, active low |
| highSupply | output | 1 | Request for the programming supply level |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| error | output | 1 | Last job ended on a failing address |
| failAddr | output | ADDR_W | Address that failed |

## Verification
The embedded assertions watch the bus protocol on every cycle. They check the strobe width and that the strobe appears only with output enable high and supply raised. They check that address and data hold still across each strobe falling edge, that the read-back window never overlaps a strobe or a driven bus, that the memory stays quiet while idle, that the pulse counter stays within its limit, and that an error flag rises only together with `done`. Other properties depend on the attached memory, and only the bench scenarios can show them: how many strobes each address receives, early stopping on a match, the failing-address report for an exhausted or impossible cell, the order and content of the written bytes, and the ignored `start`. The bench memory model needs a set number of strobes per cell and can hold pre-cleared bits.

// File: rtl/burn_pkg.sv
package burn_pkg;

  typedef enum logic [1:0] {
    TM_SETUP  = 2'd0,
    TM_PULSE  = 2'd1,
    TM_SETTLE = 2'd2
  } timerSel_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_SETUP  = 3'd2,
    ST_PULSE  = 3'd3,
    ST_SETTLE = 3'd4,
    ST_CHECK  = 3'd5,
    ST_DONE   = 3'd6
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      jobStart;
    logic      loadByte;
    logic      timerLoad;
    timerSel_e timerSel;
    logic      pulseInc;
    logic      advance;
    logic      latchFail;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic timerDone;
    logic lenZero;
    logic lastByte;
    logic match;
    logic badBit;
    logic pulseLimit;
  } dpStatus_t;

endpackage

// File: rtl/burn_datapath.sv
module burn_datapath
  import burn_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int LEN_W      = 19,
  parameter int DATA_W     = 8,
  parameter int PULSE_CYC  = 12500,
  parameter int SETUP_CYC  = 2,
  parameter int SETTLE_CYC = 2,
  parameter int MAX_PULSES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  length,
  input  logic [DATA_W-1:0] srcByte,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [ADDR_W-1:0] addrReg,
  output logic [DATA_W-1:0] dataReg,
  output dpStatus_t         status,
  output logic              errorFlag,
  output logic [ADDR_W-1:0] failAddr
);

  localparam int TMAX = (PULSE_CYC > SETUP_CYC)
                        ? ((PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC)
                        : ((SETUP_CYC > SETTLE_CYC) ? SETUP_CYC : SETTLE_CYC);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(MAX_PULSES + 1);

  logic [LEN_W-1:0] remainReg;
  logic [PW-1:0]    pulseCnt;
  logic [TW-1:0]    timer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      remainReg <= '0;
      dataReg   <= '0;
    end else begin
      if (stb.jobStart) begin
        addrReg   <= startAddr;
        remainReg <= length;
      end else if (stb.advance) begin
        addrReg   <= addrReg + 1'b1;
        remainReg <= remainReg - 1'b1;
      end
      if (stb.loadByte) dataReg <= srcByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              pulseCnt <= '0;
    else if (stb.loadByte)  pulseCnt <= '0;
    else if (stb.pulseInc)  pulseCnt <= pulseCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) timer <= '0;
    else if (stb.timerLoad) begin
      case (stb.timerSel)
        TM_SETUP:  timer <= TW'(SETUP_CYC - 1);
        TM_PULSE:  timer <= TW'(PULSE_CYC - 1);
        default:   timer <= TW'(SETTLE_CYC - 1);
      endcase
    end else if (timer != '0) timer <= timer - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errorFlag <= 1'b0;
      failAddr  <= '0;
    end else if (stb.jobStart) begin
      errorFlag <= 1'b0;
      failAddr  <= '0;
    end else if (stb.latchFail) begin
      errorFlag <= 1'b1;
      failAddr  <= addrReg;
    end
  end

  always_comb begin
    status.timerDone  = (timer == '0);
    status.lenZero    = (length == '0);
    status.lastByte   = (remainReg == LEN_W'(1));
    status.match      = (memDataIn == dataReg);
    status.badBit     = |(~memDataIn & dataReg);
    status.pulseLimit = (pulseCnt >= PW'(MAX_PULSES));
  end

  // R7: the per-address strobe count never passes the limit
  assert_pulse_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PW'(MAX_PULSES));

  // R6: strobe count restarts for every new byte
  assert_count_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadByte |=> pulseCnt == '0);

endmodule

// File: rtl/burn_ctrl.sv
module burn_ctrl
  import burn_pkg::*;
#(
  parameter int PULSE_CYC = 12500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   status,
  output ctrlStrobe_t stb,
  output logic        memDataOe,
  output logic        memCeN,
  output logic        memOeN,
  output logic        memPgmN,
  output logic        highSupply,
  output logic        busy,
  output logic        done
);

  localparam int LW = $clog2(PULSE_CYC + 1);

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    case (state)
      ST_IDLE: if (start) begin
        stb.jobStart = 1'b1;
        nextState    = status.lenZero ? ST_DONE : ST_LOAD;
      end
      ST_LOAD: begin
        stb.loadByte  = 1'b1;
        stb.timerLoad = 1'b1;
        stb.timerSel  = TM_SETUP;
        nextState     = ST_SETUP;
      end
      ST_SETUP: if (status.timerDone) begin
        stb.timerLoad = 1'b1;
        stb.timerSel  = TM_PULSE;
        stb.pulseInc  = 1'b1;
        nextState     = ST_PULSE;
      end
      ST_PULSE: if (status.timerDone) begin
        stb.timerLoad = 1'b1;
        stb.timerSel  = TM_SETTLE;
        nextState     = ST_SETTLE;
      end
      ST_SETTLE: if (status.timerDone) nextState = ST_CHECK;
      ST_CHECK: begin
        if (status.match) begin
          if (status.lastByte) nextState = ST_DONE;
          else begin
            stb.advance = 1'b1;
            nextState   = ST_LOAD;
          end
        end else if (status.badBit || status.pulseLimit) begin
          stb.latchFail = 1'b1;
          nextState     = ST_DONE;
        end else begin
          stb.timerLoad = 1'b1;
          stb.timerSel  = TM_SETUP;
          nextState     = ST_SETUP;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    busy       = (state != ST_IDLE) && (state != ST_DONE);
    done       = (state == ST_DONE);
    highSupply = busy;
    memCeN     = !busy;
    memOeN     = !((state == ST_SETTLE) || (state == ST_CHECK));
    memPgmN    = (state != ST_PULSE);
    memDataOe  = (state == ST_SETUP) || (state == ST_PULSE);
  end

  // checker-side run length of the strobe
  logic [LW-1:0] lowRun;
  always_ff @(posedge clk) begin
    if (!rstN)        lowRun <= '0;
    else if (!memPgmN) lowRun <= lowRun + 1'b1;
    else              lowRun <= '0;
  end

  assert_pulse_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
    !memPgmN |-> (memOeN && !memCeN && highSupply && memDataOe));

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memPgmN && lowRun != '0) |-> lowRun == LW'(PULSE_CYC));

  assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= LW'(PULSE_CYC));

  assert_verify_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memPgmN && !memDataOe && !memCeN));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!highSupply && memCeN && memOeN && memPgmN && !memDataOe));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/burn_sequencer.sv
module burn_sequencer
  import burn_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int LEN_W      = 19,
  parameter int DATA_W     = 8,
  parameter int PULSE_CYC  = 12500,
  parameter int SETUP_CYC  = 2,
  parameter int SETTLE_CYC = 2,
  parameter int MAX_PULSES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  length,
  output logic [ADDR_W-1:0] srcAddr,
  input  logic [DATA_W-1:0] srcByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memPgmN,
  output logic              highSupply,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] failAddr
);

  ctrlStrobe_t       stb;
  dpStatus_t         status;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;

  burn_ctrl #(.PULSE_CYC(PULSE_CYC)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .status(status), .stb(stb),
    .memDataOe(memDataOe), .memCeN(memCeN), .memOeN(memOeN),
    .memPgmN(memPgmN), .highSupply(highSupply), .busy(busy), .done(done)
  );

  burn_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC),
    .SETUP_CYC(SETUP_CYC), .SETTLE_CYC(SETTLE_CYC), .MAX_PULSES(MAX_PULSES)
  ) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .startAddr(startAddr), .length(length),
    .srcByte(srcByte), .memDataIn(memDataIn), .addrReg(addrReg),
    .dataReg(dataReg), .status(status), .errorFlag(error), .failAddr(failAddr)
  );

  assign srcAddr    = addrReg;
  assign memAddr    = addrReg;
  assign memDataOut = dataReg;

  // R4: bus already driven and steady at the strobe's falling edge
  assert_setup_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memPgmN) |-> ($past(memDataOe) && $stable(memAddr) && $stable(memDataOut)));

  // R4: nothing moves while the strobe is low
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!memPgmN && $past(!memPgmN)) |-> ($stable(memAddr) && $stable(memDataOut)));

  // R7: an error only appears together with the end-of-job pulse
  assert_error_with_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> done);

endmodule

// File: tb/burn_sequencer_test.sv
module burn_sequencer_test;

  localparam int AW = 8;
  localparam int LW = 9;
  localparam int DW = 8;
  localparam int PULSE = 5;
  localparam int SETUP = 2;
  localparam int SETTLE = 3;
  localparam int MAXP = 10;
  localparam logic [8:0] NONE = 9'h1FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [LW-1:0] length = '0;
  logic [AW-1:0] srcAddr, memAddr, failAddr;
  logic [DW-1:0] srcByte, memDataOut, memDataIn;
  logic memDataOe, memCeN, memOeN, memPgmN, highSupply, busy, done, error;

  always #2 clk = ~clk;  // 250 MHz

  burn_sequencer #(.ADDR_W(AW), .LEN_W(LW), .DATA_W(DW), .PULSE_CYC(PULSE),
    .SETUP_CYC(SETUP), .SETTLE_CYC(SETTLE), .MAX_PULSES(MAXP)) uut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr), .length(length),
    .srcAddr(srcAddr), .srcByte(srcByte), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .memDataIn(memDataIn), .memCeN(memCeN), .memOeN(memOeN),
    .memPgmN(memPgmN), .highSupply(highSupply), .busy(busy), .done(done),
    .error(error), .failAddr(failAddr));

  // byte source: top bit always 0, so never the erased value
  function automatic logic [7:0] srcOf(input int a);
    return {1'b0, 7'(a) ^ 7'h2A};
  endfunction
  assign srcByte = srcOf(int'(srcAddr));

  // memory model
  logic [7:0] cells [256];
  int pulses [256];
  int need [256];
  assign memDataIn = (!memCeN && !memOeN) ? cells[memAddr] : 8'hFF;

  int checks = 0, errors = 0, doneCount = 0, cycles = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bus monitor
  bit prevPgm = 1'b1, prevOe = 1'b1;
  int lowRun = 0, setupRun = 0, verRun = 0;
  logic [7:0] pAddr, pData;
  always @(negedge clk) begin
    if (rstN) begin
      if (done) doneCount++;
      if (!memPgmN) begin
        if (prevPgm) begin
          check(setupRun >= SETUP, "R4 setup", setupRun, SETUP);
          pAddr = memAddr; pData = memDataOut;
        end else
          check(memAddr == pAddr && memDataOut == pData, "R4 hold", memAddr, pAddr);
        check(memOeN && !memCeN && highSupply && memDataOe, "R3 mode", memOeN, 1);
        lowRun++;
      end else if (!prevPgm) begin
        check(lowRun == PULSE, "R3 width", lowRun, PULSE);
        lowRun = 0;
        pulses[memAddr]++;
        if (pulses[memAddr] >= need[memAddr]) cells[memAddr] = cells[memAddr] & pData;
      end
      if (memDataOe && memPgmN) setupRun++;
      else if (!memDataOe) setupRun = 0;
      if (!memOeN) begin
        verRun++;
        if (verRun == 1)
          check(memPgmN && !memDataOe && !memCeN, "R5 mode", memDataOe, 0);
      end else if (!prevOe) begin
        check(verRun == SETTLE + 1, "R5 window", verRun, SETTLE + 1);
        verRun = 0;
      end
      prevPgm = memPgmN; prevOe = memOeN;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic prep(input int n, input logic [8:0] hard, input logic [8:0] stuck);
    for (int i = 0; i < 256; i++) begin
      cells[i] = 8'hFF; pulses[i] = 0; need[i] = n;
    end
    if (hard != NONE) need[hard] = MAXP + 1;
    if (stuck != NONE) cells[stuck] = 8'h00;
  endtask

  task automatic kick(input int sa, input int len);
    @(negedge clk);
    startAddr = AW'(sa); length = LW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // returns when done is seen at a negedge
  task automatic waitDone();
    int guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk); guard++;
    end
  endtask

  typedef struct packed {
    logic [7:0] sa;
    logic [8:0] len;
    logic [3:0] n;
    logic [8:0] hard;
    logic [8:0] stuck;
    logic       expErr;
    logic [7:0] expFail;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{8'd10,  9'd4, 4'd1,  NONE,   NONE,   1'b0, 8'd0},
    '{8'd50,  9'd3, 4'd3,  NONE,   NONE,   1'b0, 8'd0},
    '{8'd100, 9'd2, 4'd10, NONE,   NONE,   1'b0, 8'd0},
    '{8'd254, 9'd2, 4'd2,  NONE,   NONE,   1'b0, 8'd0},
    '{8'd20,  9'd5, 4'd1,  9'd22,  NONE,   1'b1, 8'd22},
    '{8'd30,  9'd4, 4'd2,  NONE,   9'd31,  1'b1, 8'd31},
    '{8'd0,   9'd1, 4'd1,  NONE,   NONE,   1'b0, 8'd0}
  };

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && memCeN && memOeN && memPgmN && !highSupply && !memDataOe,
          "R1 reset", {busy, done, error, highSupply}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !error && memCeN && memPgmN && !highSupply,
          "R1 after release", {busy, done, error, highSupply}, 0);

    foreach (VEC[k]) begin
      int lastA;
      prep(int'(VEC[k].n), VEC[k].hard, VEC[k].stuck);
      doneCount = 0;
      kick(int'(VEC[k].sa), int'(VEC[k].len));
      check(busy && highSupply, "R10 busy during job", busy, 1);
      waitDone();
      check(error == VEC[k].expErr, "R7/R8 error flag", error, VEC[k].expErr);
      if (VEC[k].expErr)
        check(failAddr == VEC[k].expFail, "R7/R8 failAddr", failAddr, VEC[k].expFail);
      @(negedge clk);
      check(!done && !busy && !highSupply && memCeN, "R10 end idle", done, 0);
      check(doneCount == 1, "R10 done once", doneCount, 1);
      check(error == VEC[k].expErr, "R10 error held", error, VEC[k].expErr);
      lastA = VEC[k].expErr ? int'(VEC[k].expFail) : int'(VEC[k].sa) + int'(VEC[k].len) - 1;
      for (int a = 0; a < 256; a++) begin
        bool_chk: begin
          bit inRange;
          inRange = (a >= int'(VEC[k].sa)) && (a < int'(VEC[k].sa) + int'(VEC[k].len));
          if (!inRange || a > lastA) begin
            if (!(VEC[k].stuck != NONE && a == int'(VEC[k].stuck)))
              check(pulses[a] == 0 && cells[a] == 8'hFF, "R9 untouched", pulses[a], 0);
          end else if (a < lastA || !VEC[k].expErr) begin
            check(cells[a] == srcOf(a), "R9 content", cells[a], srcOf(a));
            check(pulses[a] == int'(VEC[k].n), "R6 pulse count", pulses[a], VEC[k].n);
          end
        end
      end
      if (VEC[k].hard != NONE)
        check(pulses[VEC[k].hard] == MAXP, "R7 ten pulses", pulses[VEC[k].hard], MAXP);
      if (VEC[k].stuck != NONE)
        check(pulses[VEC[k].stuck] == 1, "R8 stop at once", pulses[VEC[k].stuck], 1);
    end

    // R10: error cleared by next start; R11: zero length
    prep(1, NONE, NONE);
    doneCount = 0;
    kick(40, 0);
    check(done && !busy && !error, "R11 immediate done", done, 1);
    @(negedge clk);
    check(doneCount == 1 && !done, "R11 single done", doneCount, 1);
    for (int a = 0; a < 256; a++)
      if (pulses[a] != 0) check(1'b0, "R11 no strobe", pulses[a], 0);
    check(!error && failAddr == 0, "R10 error cleared on start", error, 0);

    // R2: start while busy is ignored
    prep(2, NONE, NONE);
    doneCount = 0;
    kick(60, 2);
    repeat (6) @(negedge clk);
    startAddr = 8'd200; length = 9'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(doneCount == 1, "R2 one job only", doneCount, 1);
    check(pulses[200] == 0 && cells[200] == 8'hFF, "R2 ignored start", pulses[200], 0);
    check(cells[60] == srcOf(60) && cells[61] == srcOf(61), "R2 job intact", cells[61], srcOf(61));
    check(!busy, "R2 idle after", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule